// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pin-Change and Edge Interrupts

This block is an 8-bit general-purpose I/O port that sits behind a small register bus. Each pin has an output latch and a direction bit. The pad is reached through three abstract signals per pin: an output enable, an output value and a weak pull-up enable. Pin inputs pass through a synchronizer before the port reads them or any interrupt logic looks at them.

The upper four pins can raise a sticky change interrupt. Each of them that is set as an input is compared against a snapshot of the pins. The snapshot is taken whenever software reads or writes the port register, not on every clock. The same flag also drives a wake request. Pin 0 doubles as an external interrupt input, and a configuration bit picks which edge sets its own flag. Software clears a flag by writing 0 to its bit. A mismatch that is still present sets the change flag again at once.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset the direction register reads 0xFF (all inputs), the output latch is 0, both flags are 0, the configuration register reads 0x03 (pull-ups off, rising edge), no pad output is enabled and no pull-up is enabled.
- R2: A direction bit of 0 drives that pin's pad output enable high with the output latch value on pad_out. A direction bit of 1 turns the output enable off. A write to the port register loads the output latch on the next clock.
- R3: The configuration register has bit 0 as an active-low global pull-up control. pad_pu[i] is high exactly when that bit is 0 and pin i is an input. A pin never has both its pull-up and its output enable high.
- R4: Register addresses are 0 = port, 1 = direction, 2 = configuration, 3 = flags. Read data is combinational. A port read returns the pin values after a two-flop synchronizer. The flags register has bit 0 = change flag and bit 1 = edge flag.
- R5: If an input pin among pins 7..4 differs from the snapshot, the change flag is set. The flag becomes visible on the third rising clock edge after the pad changes, and it stays set until it is cleared.
- R6: Pins 3..0 never set the change flag. A pin among 7..4 that is set as an output is left out of the comparison.
- R7: A read or a write of the port register loads the snapshot with the synchronized pins. After that, a clear of the change flag takes effect.
- R8: While a mismatch persists, a clear of the change flag does not leave it cleared.
- R9: If a set condition and a clear of the same flag occur in the same cycle, the flag ends up set.
- R10: wake_req is high whenever the change flag is set.
- R11: Configuration bit 1 selects the edge on synchronized pin 0: 1 = rising, 0 = falling. The selected edge sets the edge flag and the opposite edge leaves it unchanged.
- R12: Writing 0 to a flag bit in register 3 clears that flag. Writing 1 to a flag bit leaves that flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (port read updates snapshot) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| pad_in | input | 8 | Raw pad input values |
| pad_out | output | 8 | Output latch to pad drivers |
| pad_oe | output | 8 | Per-pin output enable |
| pad_pu | output | 8 | Per-pin weak pull-up enable |
| chg_irq | output | 1 | Sticky change flag of pins 7..4 |
| ext_irq | output | 1 | Sticky edge flag of pin 0 |
| wake_req | output | 1 | Wake request from the change flag |

## Verification
The change logic is exercised with four kinds of stimulus:
- a single upper input pin toggling, followed by a read and a clear, which separates comparing against the snapshot from comparing against the last clock sample;
- a second pin changing with no read before the clear, which shows that the flag re-asserts while the mismatch persists;
- the lower pins toggling, and an upper pin toggling while it is set as an output, which shows that the comparison is masked;
- a port write in place of a read, which shows that both kinds of access refresh the snapshot.

Pin 0 is driven through rising and falling edges under both edge settings, which separates the selected edge from the opposite one. Flag writes of 1 and 0 separate a clear from a no-op.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      REG_PORT = 2'd0,
      REG_DIR  = 2'd1,
      REG_CFG  = 2'd2,
      REG_FLAG = 2'd3
   } reg_sel_e;

   localparam int CFG_PULL_N_BIT = 0;
   localparam int CFG_RISE_BIT   = 1;
   localparam int FLAG_CHG_BIT   = 0;
   localparam int FLAG_EXT_BIT   = 1;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[0] <= '0;
      else        stg_q[0] <= din;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q[k] <= '0;
         else        stg_q[k] <= stg_q[k-1];
      end
   end

   assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_chg_det.sv
module gpio_chg_det #(
   parameter int WIDTH  = 8,
   parameter int CHG_LO = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pins_s,
   input  logic [WIDTH-1:0] dir,
   input  logic             access,
   input  logic             clr,
   output logic             hit,
   output logic             flag
);

   localparam int NCHG = WIDTH - CHG_LO;

   logic [NCHG-1:0] snap_q;
   logic [NCHG-1:0] diff;

   for (genvar i = 0; i < NCHG; i++) begin : g_cmp
      assign diff[i] = dir[CHG_LO+i] & (pins_s[CHG_LO+i] ^ snap_q[i]);
   end

   assign hit = |diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      snap_q <= '0;
      else if (access) snap_q <= pins_s[WIDTH-1:CHG_LO];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (hit) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

endmodule

// File: rtl/gpio_ext_edge.sv
module gpio_ext_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic rise_sel,
   input  logic clr,
   output logic edge_hit,
   output logic flag
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin_s;
   end

   assign edge_hit = rise_sel ? (pin_s & ~prev_q) : (~pin_s & prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (edge_hit) flag <= 1'b1;
      else if (clr)      flag <= 1'b0;
   end

endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
   import gpio_port_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int CHG_LO      = 4,
   parameter int EXT_PIN     = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       reg_addr,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [WIDTH-1:0] reg_wdata,
   output logic [WIDTH-1:0] reg_rdata,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_pu,
   output logic             chg_irq,
   output logic             ext_irq,
   output logic             wake_req
);

   if (WIDTH < 2 || CHG_LO < 1 || CHG_LO >= WIDTH ||
       EXT_PIN < 0 || EXT_PIN >= CHG_LO || SYNC_STAGES < 2) begin : g_bad_cfg
      $error("gpio_chg_port: illegal parameter set");
   end

   reg_sel_e         sel;
   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] dir_q;
   logic             pull_n_q;
   logic             rise_q;
   logic [WIDTH-1:0] pins_s;
   logic             port_access;
   logic             wr_flag;
   logic             chg_clr;
   logic             ext_clr;
   logic             chg_hit;
   logic             ext_hit;

   assign sel         = reg_sel_e'(reg_addr);
   assign port_access = (reg_wr | reg_rd) && (sel == REG_PORT);
   assign wr_flag     = reg_wr && (sel == REG_FLAG);
   assign chg_clr     = wr_flag && !reg_wdata[FLAG_CHG_BIT];
   assign ext_clr     = wr_flag && !reg_wdata[FLAG_EXT_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q  <= '0;
         dir_q    <= '1;
         pull_n_q <= 1'b1;
         rise_q   <= 1'b1;
      end else if (reg_wr) begin
         unique case (sel)
            REG_PORT: latch_q <= reg_wdata;
            REG_DIR:  dir_q   <= reg_wdata;
            REG_CFG: begin
               pull_n_q <= reg_wdata[CFG_PULL_N_BIT];
               rise_q   <= reg_wdata[CFG_RISE_BIT];
            end
            default: ;
         endcase
      end
   end

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pad_in),
      .dout (pins_s)
   );

   gpio_chg_det #(.WIDTH(WIDTH), .CHG_LO(CHG_LO)) u_chg (
      .clk   (clk),
      .rst_n (rst_n),
      .pins_s(pins_s),
      .dir   (dir_q),
      .access(port_access),
      .clr   (chg_clr),
      .hit   (chg_hit),
      .flag  (chg_irq)
   );

   gpio_ext_edge u_ext (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_s   (pins_s[EXT_PIN]),
      .rise_sel(rise_q),
      .clr     (ext_clr),
      .edge_hit(ext_hit),
      .flag    (ext_irq)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_pad
      assign pad_oe[i]  = ~dir_q[i];
      assign pad_out[i] = latch_q[i];
      assign pad_pu[i]  = ~pull_n_q & dir_q[i];
   end

   assign wake_req = chg_irq;

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         REG_PORT: reg_rdata = pins_s;
         REG_DIR:  reg_rdata = dir_q;
         REG_CFG: begin
            reg_rdata[CFG_PULL_N_BIT] = pull_n_q;
            reg_rdata[CFG_RISE_BIT]   = rise_q;
         end
         REG_FLAG: begin
            reg_rdata[FLAG_CHG_BIT] = chg_irq;
            reg_rdata[FLAG_EXT_BIT] = ext_irq;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       reg_addr,
   input logic             reg_wr,
   input logic [WIDTH-1:0] reg_wdata,
   input logic [WIDTH-1:0] pad_out,
   input logic [WIDTH-1:0] pad_oe,
   input logic [WIDTH-1:0] pad_pu,
   input logic             chg_irq,
   input logic             ext_irq,
   input logic             wake_req,
   input logic             chg_hit,
   input logic             ext_hit
);

   logic flag_wr;
   assign flag_wr = reg_wr && (reg_addr == 2'd3);

   AST_PU_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_oe) == '0); // R3

   AST_PORT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd0) |=> pad_out == $past(reg_wdata)); // R2

   AST_CHG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      chg_hit |=> chg_irq); // R8

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_hit && flag_wr && !reg_wdata[0]) |=> chg_irq); // R9

   AST_CHG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_irq && !(flag_wr && !reg_wdata[0])) |=> chg_irq); // R5

   AST_CHG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && !reg_wdata[0] && !chg_hit) |=> !chg_irq); // R12

   AST_EXT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ext_hit |=> ext_irq); // R11

   AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_irq && !(flag_wr && !reg_wdata[1])) |=> ext_irq); // R12

   AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chg_irq) |-> wake_req); // R10

endmodule

bind gpio_chg_port gpio_chg_port_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_addr (reg_addr),
   .reg_wr   (reg_wr),
   .reg_wdata(reg_wdata),
   .pad_out  (pad_out),
   .pad_oe   (pad_oe),
   .pad_pu   (pad_pu),
   .chg_irq  (chg_irq),
   .ext_irq  (ext_irq),
   .wake_req (wake_req),
   .chg_hit  (chg_hit),
   .ext_hit  (ext_hit)
);

// File: tb/gpio_chg_port_tb.sv
module gpio_chg_port_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [7:0] pad_in = '0;
   logic [7:0] pad_out, pad_oe, pad_pu;
   logic       chg_irq, ext_irq, wake_req;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   gpio_chg_port u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
      .chg_irq(chg_irq), .ext_irq(ext_irq), .wake_req(wake_req)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pins(input logic [7:0] v);
      @(negedge clk);
      pad_in = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      peek(2'd1, d); chk("R1 dir", d, 8'hFF);
      peek(2'd2, d); chk("R1 cfg", d, 8'h03);
      peek(2'd3, d); chk("R1 flags", d, 8'h00);
      chk("R1 pad_out", pad_out, 8'h00);
      chk("R1 pad_oe", pad_oe, 8'h00);
      chk("R1 pad_pu", pad_pu, 8'h00);
   endtask

   task automatic t_direction;
      logic [7:0] d;
      wr(2'd1, 8'hCF);
      wr(2'd0, 8'hA5);
      chk("R2 pad_oe", pad_oe, 8'h30);
      chk("R2 pad_out", pad_out, 8'hA5);
      peek(2'd1, d); chk("R4 dir readback", d, 8'hCF);
      wr(2'd2, 8'h02);
      chk("R3 pad_pu on", pad_pu, 8'hCF);
      wr(2'd1, 8'hFF);
      chk("R3 pad_pu all inputs", pad_pu, 8'hFF);
      wr(2'd2, 8'h03);
      chk("R3 pad_pu off", pad_pu, 8'h00);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_change_read;
      logic [7:0] d;
      pins(8'h20);
      chk("R5 chg set", {7'd0, chg_irq}, 8'h01);
      chk("R10 wake", {7'd0, wake_req}, 8'h01);
      rd(2'd0, d); chk("R4 port read", d, 8'h20);
      wr(2'd3, 8'h00);
      chk("R7 clear after read", {7'd0, chg_irq}, 8'h00);
      repeat (3) @(negedge clk);
      chk("R7 stays clear", {7'd0, chg_irq}, 8'h00);
   endtask

   task automatic t_persist;
      logic [7:0] d;
      pins(8'h60);
      wr(2'd3, 8'h00);
      chk("R8 reasserts", {7'd0, chg_irq}, 8'h01);
      chk("R9 set wins", {7'd0, wake_req}, 8'h01);
      rd(2'd0, d);
      wr(2'd3, 8'h00);
      chk("R7 clear after second read", {7'd0, chg_irq}, 8'h00);
   endtask

   task automatic t_masked;
      logic [7:0] d;
      pins(8'h6E);
      repeat (2) @(negedge clk);
      chk("R6 low pins ignored", {7'd0, chg_irq}, 8'h00);
      wr(2'd1, 8'h7F);
      pins(8'hEE);
      repeat (2) @(negedge clk);
      chk("R6 output pin ignored", {7'd0, chg_irq}, 8'h00);
      chk("R2 pin7 driven", pad_oe, 8'h80);
      pins(8'h60);
      wr(2'd1, 8'hFF);
      rd(2'd0, d);
      chk("R4 port read masked", d, 8'h60);
      chk("R6 no flag after restore", {7'd0, chg_irq}, 8'h00);
   endtask

   task automatic t_write_snap;
      pins(8'h70);
      chk("R5 pin4 change", {7'd0, chg_irq}, 8'h01);
      wr(2'd0, 8'h00);
      wr(2'd3, 8'h00);
      chk("R7 clear after write", {7'd0, chg_irq}, 8'h00);
   endtask

   task automatic t_ext;
      pins(8'h71);
      chk("R11 rising sets", {7'd0, ext_irq}, 8'h01);
      wr(2'd3, 8'h02);
      chk("R12 write 1 keeps", {7'd0, ext_irq}, 8'h01);
      wr(2'd3, 8'h01);
      chk("R12 write 0 clears", {7'd0, ext_irq}, 8'h00);
      chk("R12 chg untouched", {7'd0, chg_irq}, 8'h00);
      pins(8'h70);
      chk("R11 falling ignored", {7'd0, ext_irq}, 8'h00);
      wr(2'd2, 8'h01);
      pins(8'h71);
      chk("R11 rising ignored", {7'd0, ext_irq}, 8'h00);
      pins(8'h70);
      chk("R11 falling sets", {7'd0, ext_irq}, 8'h01);
   endtask

   initial begin
      #800000;
      checks++;
      errors++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_direction();
      t_change_read();
      t_persist();
      t_masked();
      t_write_snap();
      t_ext();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule